// File: doc/BRIEF.md
# Programmer-Visible Register Bank with Constant Sources

This block holds the software-visible registers of a small 32-bit processor. Two read ports and one write port each pick a register with a 4-bit selector. Eight selectors reach general-purpose 32-bit registers. One reaches a 16-bit stack pointer and one reaches a status word that carries three flags. Three further selectors return fixed values (plus one, zero and all ones), so an instruction can name a constant as though it were a register.

Both reads are combinational. The write port updates its target on the rising clock edge. A separate overflow strobe lets the arithmetic unit update the overflow flag without a full register write. The three status flags are also driven out continuously, so that interrupt and timer logic can follow them.

Top module: `regbank_top`

## Requirements
- R1: Selectors 0x0 to 0x7 address eight independent 32-bit general registers. A write with `wr_en` high stores all 32 bits, and a cycle with `wr_en` low changes nothing.
- R2: Selector 0x8 addresses a 16-bit stack pointer. A write keeps only `wr_data[15:0]`, and a read returns that value with bits 31:16 equal to zero.
- R3: Selector 0x9 addresses the status word. Bit 0 is overflow, bit 1 is interrupt mask and bit 2 is timer enable. A write keeps `wr_data[2:0]`, and a read returns zero in bits 31:3. `status_flags` always shows bits 2:0, and they hold their value unless a status write or an overflow strobe occurs.
- R4: A read of selector 0xB returns 0x00000001, of 0xC returns 0x00000000, and of 0xD returns 0xFFFFFFFF. Writes to these three selectors change no register.
- R5: Selectors 0xA, 0xE and 0xF read as zero, and writes to them change no register.
- R6: When `ovf_upd` is high in a cycle with no status write, bit 0 of the status word takes `ovf_val` at that edge, and bits 2:1 keep their value.
- R7: When `ovf_upd` and a status write occur in the same cycle, the status word takes the written bits 2:0 and `ovf_val` has no effect.
- R8: While `rst_n` is low at a rising clock edge, all general registers, the stack pointer and the status word clear to zero.
- R9: The two read ports decode their selectors independently and combinationally. A written value appears on a read port after the next rising edge, and in the cycle of the write the port still shows the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_a_sel | input | 4 | Register selector for read port A |
| rd_a_data | output | 32 | Read port A data, combinational |
| rd_b_sel | input | 4 | Register selector for read port B |
| rd_b_data | output | 32 | Read port B data, combinational |
| wr_en | input | 1 | Write enable |
| wr_sel | input | 4 | Register selector for the write |
| wr_data | input | 32 | Write data |
| ovf_upd | input | 1 | Overflow flag update strobe |
| ovf_val | input | 1 | New overflow flag value |
| status_flags | output | 3 | Status bits: [2] timer enable, [1] interrupt mask, [0] overflow |

## Verification
Read data is combinational, so a read result is due in the same cycle as its selector. The bench changes selectors just after a falling edge and samples one time step later. A write, an overflow strobe or a reset acts at the rising edge. The bench drives these at a falling edge and checks ports and `status_flags` at the following falling edge, one register stage later. A check placed before that edge confirms the old value is still visible while the write is pending.

// File: rtl/regbank_pkg.sv
// Package: shared widths, selector codes and the status word layout.
// Assumes selectors are 4 bits and general registers start at code 0.
package regbank_pkg;
    localparam int SEL_W = 4;
    localparam int SR_W  = 3;

    localparam logic [SEL_W-1:0] SEL_SP   = 4'h8;
    localparam logic [SEL_W-1:0] SEL_SR   = 4'h9;
    localparam logic [SEL_W-1:0] SEL_ONE  = 4'hB;
    localparam logic [SEL_W-1:0] SEL_ZERO = 4'hC;
    localparam logic [SEL_W-1:0] SEL_MONE = 4'hD;

    // Bit order is behaviour: [2] timer enable, [1] irq mask, [0] overflow.
    typedef struct packed {
        logic tmr_en;
        logic irq_mask;
        logic ovf;
    } sr_t;
endpackage

// File: rtl/regbank_wdec.sv
// Module: write-port decoder. Turns wr_en/wr_sel into one strobe per
// storage element. Constant and unused codes raise no strobe.
// Assumes N_GPR <= 8 so general codes never overlap the special codes.
module regbank_wdec
    import regbank_pkg::*;
#(
    parameter int N_GPR = 8
) (
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    output logic [N_GPR-1:0] gpr_we,
    output logic             sp_we,
    output logic             sr_we
);
    // One comparator per general register.
    for (genvar g = 0; g < N_GPR; g++) begin : g_gpr_dec
        localparam logic [SEL_W-1:0] CODE = SEL_W'(g);
        assign gpr_we[g] = wr_en && (wr_sel == CODE);
    end

    // Special storage strobes.
    assign sp_we = wr_en && (wr_sel == SEL_SP);
    assign sr_we = wr_en && (wr_sel == SEL_SR);
endmodule

// File: rtl/regbank_gpr.sv
// Module: storage for the general registers and the stack pointer.
// Assumes at most one strobe is high per cycle (guaranteed by the decoder).
module regbank_gpr #(
    parameter int DATA_W = 32,
    parameter int SP_W   = 16,
    parameter int N_GPR  = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [N_GPR-1:0]             gpr_we,
    input  logic                         sp_we,
    input  logic [DATA_W-1:0]            wr_data,
    output logic [N_GPR-1:0][DATA_W-1:0] gpr_q,
    output logic [SP_W-1:0]              sp_q
);
    // One register per general code, cleared by reset.
    for (genvar g = 0; g < N_GPR; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n)
                gpr_q[g] <= '0;
            else if (gpr_we[g])
                gpr_q[g] <= wr_data;
        end
    end

    // Stack pointer keeps only the low SP_W bits of a write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sp_q <= '0;
        else if (sp_we)
            sp_q <= wr_data[SP_W-1:0];
    end
endmodule

// File: rtl/regbank_sr.sv
// Module: status word. A port write replaces all three flags. The
// overflow strobe replaces only bit 0, and a port write wins over it.
// Assumes the caller passes only the low three data bits.
module regbank_sr
    import regbank_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sr_we,
    input  logic [SR_W-1:0] wr_bits,
    input  logic            ovf_upd,
    input  logic            ovf_val,
    output sr_t             sr_q
);
    // Priority: reset, then register write, then overflow strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sr_q <= '0;
        else if (sr_we)
            sr_q <= sr_t'(wr_bits);
        else if (ovf_upd)
            sr_q.ovf <= ovf_val;
    end
endmodule

// File: rtl/regbank_rdmux.sv
// Module: one combinational read port. Maps a selector onto stored or
// constant values. Unused codes read zero.
// Assumes N_GPR is a power of two no larger than 8.
module regbank_rdmux
    import regbank_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SP_W   = 16,
    parameter int N_GPR  = 8
) (
    input  logic [SEL_W-1:0]             rd_sel,
    input  logic [N_GPR-1:0][DATA_W-1:0] gpr_q,
    input  logic [SP_W-1:0]              sp_q,
    input  sr_t                          sr_q,
    output logic [DATA_W-1:0]            rd_data
);
    localparam int               IDX_W   = (N_GPR > 1) ? $clog2(N_GPR) : 1;
    localparam logic [SEL_W-1:0] GPR_LIM = SEL_W'(N_GPR);

    // Selector decode; the default covers the unused codes.
    always_comb begin
        rd_data = '0;
        if (rd_sel < GPR_LIM) begin
            rd_data = gpr_q[rd_sel[IDX_W-1:0]];
        end else begin
            unique case (rd_sel)
                SEL_SP:   rd_data = {{(DATA_W-SP_W){1'b0}}, sp_q};
                SEL_SR:   rd_data = {{(DATA_W-SR_W){1'b0}}, sr_q};
                SEL_ONE:  rd_data = DATA_W'(1);
                SEL_ZERO: rd_data = '0;
                SEL_MONE: rd_data = '1;
                default:  rd_data = '0;
            endcase
        end
    end
endmodule

// File: rtl/regbank_top.sv
// Module: register bank top. Joins the write decoder, the storage, the
// status word and two identical read ports.
// Assumes a single clock domain and synchronous active-low reset.
module regbank_top
    import regbank_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SP_W   = 16,
    parameter int N_GPR  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        rd_a_sel,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [3:0]        rd_b_sel,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [3:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ovf_upd,
    input  logic              ovf_val,
    output logic [2:0]        status_flags
);
    logic [N_GPR-1:0]             gpr_we;
    logic                         sp_we;
    logic                         sr_we;
    logic [N_GPR-1:0][DATA_W-1:0] gpr_q;
    logic [SP_W-1:0]              sp_q;
    sr_t                          sr_q;

    regbank_wdec #(.N_GPR(N_GPR)) u_wdec (
        .wr_en  (wr_en),
        .wr_sel (wr_sel),
        .gpr_we (gpr_we),
        .sp_we  (sp_we),
        .sr_we  (sr_we)
    );

    regbank_gpr #(.DATA_W(DATA_W), .SP_W(SP_W), .N_GPR(N_GPR)) u_gpr (
        .clk     (clk),
        .rst_n   (rst_n),
        .gpr_we  (gpr_we),
        .sp_we   (sp_we),
        .wr_data (wr_data),
        .gpr_q   (gpr_q),
        .sp_q    (sp_q)
    );

    regbank_sr u_sr (
        .clk     (clk),
        .rst_n   (rst_n),
        .sr_we   (sr_we),
        .wr_bits (wr_data[SR_W-1:0]),
        .ovf_upd (ovf_upd),
        .ovf_val (ovf_val),
        .sr_q    (sr_q)
    );

    regbank_rdmux #(.DATA_W(DATA_W), .SP_W(SP_W), .N_GPR(N_GPR)) u_rd_a (
        .rd_sel  (rd_a_sel),
        .gpr_q   (gpr_q),
        .sp_q    (sp_q),
        .sr_q    (sr_q),
        .rd_data (rd_a_data)
    );

    regbank_rdmux #(.DATA_W(DATA_W), .SP_W(SP_W), .N_GPR(N_GPR)) u_rd_b (
        .rd_sel  (rd_b_sel),
        .gpr_q   (gpr_q),
        .sp_q    (sp_q),
        .sr_q    (sr_q),
        .rd_data (rd_b_data)
    );

    // Flags go out for interrupt and timer logic.
    assign status_flags = sr_q;
endmodule

// File: rtl/regbank_chk.sv
// Module: port-level property checker for regbank_top, attached by bind.
// Assumes the default widths (32-bit data, 16-bit stack pointer, 8 GPRs).
module regbank_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [3:0]  rd_a_sel,
    input logic [31:0] rd_a_data,
    input logic [3:0]  rd_b_sel,
    input logic [31:0] rd_b_data,
    input logic        wr_en,
    input logic [3:0]  wr_sel,
    input logic [31:0] wr_data,
    input logic        ovf_upd,
    input logic        ovf_val,
    input logic [2:0]  status_flags
);
    a_r9_gpr_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel <= 4'h7) ##1 (rd_a_sel == $past(wr_sel))
        |-> rd_a_data == $past(wr_data));

    a_r2_sp_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_b_sel == 4'h8) |-> rd_b_data[31:16] == 16'h0);

    a_r3_sr_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_sel == 4'h9) |-> rd_a_data == {29'h0, status_flags});

    a_r3_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovf_upd && !(wr_en && wr_sel == 4'h9)) |=> $stable(status_flags));

    a_r4_const_mone: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_sel == 4'hD) |-> rd_a_data == 32'hFFFF_FFFF);

    a_r4_const_one: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_b_sel == 4'hB) |-> rd_b_data == 32'h1);

    a_r5_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_sel == 4'hA || rd_a_sel == 4'hE || rd_a_sel == 4'hF)
        |-> rd_a_data == 32'h0);

    a_r6_ovf_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_upd && !(wr_en && wr_sel == 4'h9))
        |=> (status_flags[0] == $past(ovf_val))
            && (status_flags[2:1] == $past(status_flags[2:1])));

    a_r7_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 4'h9) |=> status_flags == $past(wr_data[2:0]));
endmodule

bind regbank_top regbank_chk u_chk (.*);

// File: tb/regbank_top_tb.sv
// Bench: a vector table walked by one loop, then directed tests for the
// status strobe, write timing, dual reads and reset.
module regbank_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  rd_a_sel = 4'h0;
    logic [31:0] rd_a_data;
    logic [3:0]  rd_b_sel = 4'h0;
    logic [31:0] rd_b_data;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_sel = 4'h0;
    logic [31:0] wr_data = 32'h0;
    logic        ovf_upd = 1'b0;
    logic        ovf_val = 1'b0;
    logic [2:0]  status_flags;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    regbank_top u_dut (
        .clk(clk), .rst_n(rst_n),
        .rd_a_sel(rd_a_sel), .rd_a_data(rd_a_data),
        .rd_b_sel(rd_b_sel), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .ovf_upd(ovf_upd), .ovf_val(ovf_val),
        .status_flags(status_flags)
    );

    // Fields: wr_en[72] wr_sel[71:68] wr_data[67:36] rd_sel[35:32] exp[31:0]
    localparam int NV = 14;
    localparam logic [72:0] VEC [NV] = '{
        {1'b1, 4'h0, 32'h1234_5678, 4'h0, 32'h1234_5678}, // R1
        {1'b1, 4'h7, 32'hDEAD_BEEF, 4'h7, 32'hDEAD_BEEF}, // R1
        {1'b1, 4'h3, 32'hA5A5_A5A5, 4'h0, 32'h1234_5678}, // R1 other reg intact
        {1'b1, 4'h8, 32'hCAFE_1234, 4'h8, 32'h0000_1234}, // R2
        {1'b1, 4'h8, 32'hFFFF_FFFF, 4'h8, 32'h0000_FFFF}, // R2
        {1'b1, 4'h9, 32'hFFFF_FFFF, 4'h9, 32'h0000_0007}, // R3
        {1'b1, 4'h9, 32'h0000_0002, 4'h9, 32'h0000_0002}, // R3
        {1'b1, 4'hB, 32'h0000_0055, 4'hB, 32'h0000_0001}, // R4
        {1'b1, 4'hC, 32'h0000_0055, 4'hC, 32'h0000_0000}, // R4
        {1'b1, 4'hD, 32'h0000_0000, 4'hD, 32'hFFFF_FFFF}, // R4
        {1'b1, 4'hA, 32'h0000_0077, 4'hA, 32'h0000_0000}, // R5
        {1'b1, 4'hE, 32'h0000_0077, 4'hE, 32'h0000_0000}, // R5
        {1'b1, 4'hF, 32'h0000_0099, 4'h7, 32'hDEAD_BEEF}, // R5 no side effect
        {1'b0, 4'h0, 32'h0000_0000, 4'h0, 32'h1234_5678}  // R1 disabled write
    };

    function automatic string vec_tag(int i);
        case (i)
            3, 4:         return "R2";
            5, 6:         return "R3";
            7, 8, 9:      return "R4";
            10, 11, 12:   return "R5";
            default:      return "R1";
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R8: reset state on both ports and the flag output.
        for (int s = 0; s < 10; s++) begin
            rd_a_sel = 4'(s);
            rd_b_sel = 4'(s);
            #1;
            check("R8", rd_a_data, 32'h0);
            check("R8", rd_b_data, 32'h0);
        end
        check("R8", {29'h0, status_flags}, 32'h0);

        // Vector walk: write at one falling edge, read at the next.
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            wr_en   = VEC[i][72];
            wr_sel  = VEC[i][71:68];
            wr_data = VEC[i][67:36];
            @(negedge clk);
            wr_en    = 1'b0;
            rd_a_sel = VEC[i][35:32];
            rd_b_sel = VEC[i][35:32];
            #1;
            check(vec_tag(i), rd_a_data, VEC[i][31:0]);
            check(vec_tag(i), rd_b_data, VEC[i][31:0]);
        end

        // R6: strobe sets overflow, mask bit (value 2) is kept.
        @(negedge clk);
        ovf_upd = 1'b1; ovf_val = 1'b1;
        @(negedge clk);
        ovf_upd = 1'b0;
        rd_a_sel = 4'h9;
        #1;
        check("R6", {29'h0, status_flags}, 32'h3);
        check("R6", rd_a_data, 32'h3);
        // R6: strobe clears overflow.
        @(negedge clk);
        ovf_upd = 1'b1; ovf_val = 1'b0;
        @(negedge clk);
        ovf_upd = 1'b0;
        #1;
        check("R6", {29'h0, status_flags}, 32'h2);

        // R7: write and strobe together, the write wins.
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 4'h9; wr_data = 32'h4;
        ovf_upd = 1'b1; ovf_val = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; ovf_upd = 1'b0;
        #1;
        check("R7", {29'h0, status_flags}, 32'h4);

        // R9: old value visible during the write cycle, new one after.
        @(negedge clk);
        rd_a_sel = 4'h2;
        wr_en = 1'b1; wr_sel = 4'h2; wr_data = 32'h0000_0011;
        #1;
        check("R9", rd_a_data, 32'h0);
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        check("R9", rd_a_data, 32'h0000_0011);
        // R9: the two ports decode independently.
        rd_a_sel = 4'h0;
        rd_b_sel = 4'h7;
        #1;
        check("R9", rd_a_data, 32'h1234_5678);
        check("R9", rd_b_data, 32'hDEAD_BEEF);

        // R8: reset in mid-run clears stored state.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd_a_sel = 4'h7;
        rd_b_sel = 4'h8;
        #1;
        check("R8", rd_a_data, 32'h0);
        check("R8", rd_b_data, 32'h0);
        rd_a_sel = 4'h9;
        #1;
        check("R8", rd_a_data, 32'h0);
        check("R8", {29'h0, status_flags}, 32'h0);

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule